// File: doc/BRIEF.md
# Ethernet MAC Control Register File

This block is the software-visible control store of an Ethernet MAC. A host reads and writes 32-bit words through a simple strobe interface. Each access is addressed by word, not by byte. The block holds the operating mode, the interrupt pending and enable bits, three inter-frame gap values, the frame length bounds, the collision settings, the count of transmit descriptors, a set of management-port registers, the station address and two hash words. A range of word addresses opens onto a descriptor memory.

A few writes have effects beyond storing a value:
- Interrupt pending bits clear when a one is written to them.
- A write to the transmit descriptor count also moves the receive ring pointer.
- A mode write with the soft-reset bit set puts every register back to its default.
- Setting an engine-enable bit produces a one-cycle start pulse for that engine.

The block also drives some values to the datapaths as plain outputs: the engine run levels, the frame bounds and the 48-bit station address. Its interrupt line is a registered OR of the pending bits that are enabled.

Top module: `macreg_file`

Register word map: 0x00 MODE, 0x01 ISRC (pending), 0x02 IMASK, 0x03 IPG_BB, 0x04 IPG_NB1, 0x05 IPG_NB2, 0x06 FLEN, 0x07 COLL, 0x08 TXBD, 0x09 FLOW, 0x0A MG_MODE, 0x0B MG_CMD, 0x0C MG_ADDR, 0x0D MG_WDAT, 0x0E MG_RDAT, 0x0F MG_STAT, 0x10 STA_LO, 0x11 STA_HI, 0x12 HASH_LO, 0x13 HASH_HI. The descriptor window is words 0x100 to 0x13F.

## Requirements
- R1: After reset these registers read as follows, and every other register reads 0:
  - MODE = 0x0000A000
  - IPG_BB = 0x12, IPG_NB1 = 0x0C, IPG_NB2 = 0x12
  - FLEN = 0x003C0600
  - COLL = 0x000F003F
  - TXBD = 0x40
  - MG_MODE = 0x64
  - The rx_bd_idx output is 0x080.
- R2: A written value is stored ANDed with the register's writable mask, and masked bits read 0. The masks are:
  - MODE: 0x1FFFF
  - ISRC and IMASK: the low 7 bits
  - the three IPG registers: 0x7F
  - COLL: 0x003F003F
  - TXBD: 0xFF
  - FLOW, MG_CMD and MG_STAT: 0x7
  - MG_MODE: 0x1FF
  - MG_ADDR: 0x1F1F
  - MG_WDAT, MG_RDAT and STA_HI: 0xFFFF
  - FLEN, STA_LO and both HASH words: all 32 bits
- R3: An irq_evt bit sets the matching ISRC bit. A write to ISRC clears each bit written as 1 and leaves the bits written as 0 unchanged. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: The irq output is high one cycle after any ISRC bit and its IMASK bit are both 1.
- R5: A write to TXBD keeps data bits 7:0. In the same cycle it loads rx_bd_idx with that value shifted left by one.
- R6: STA_LO holds station-address bytes 3, 2, 1 and 0, from its most to its least significant byte. STA_HI holds byte 5 in bits 15:8 and byte 4 in bits 7:0. On mac_addr, byte k sits in bits 8k+7:8k.
- R7: A MODE write with bit 11 set does not store the written value. Instead it restores every register to its R1 value, clears ISRC, returns rx_bd_idx to 0x080 and raises no start pulse. Descriptor memory contents are kept.
- R8: tx_run and rx_run follow MODE bit 1 and MODE bit 0. A MODE write that takes bit 1 (or bit 0) from 0 to 1 pulses tx_start (or rx_start) for exactly the cycle after the write. Writing the bit as 0 stops that engine.
- R9: A word address a in the range 0x100 to 0x13F reads and writes descriptor word a − 0x100.
- R10: A read from an address that is neither a register nor in the window returns 0. A write to such an address changes no register and no descriptor word. Either access pulses err for one cycle.
- R11: rdata updates one cycle after a cycle with rd_en high, and holds its value while rd_en is low.
- R12: min_len shows FLEN bits 31:16 and max_len shows FLEN bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| irq_evt | input | 7 | Interrupt event pulses from the datapaths |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle unmapped-access strobe |
| irq | output | 1 | Interrupt request |
| tx_run | output | 1 | Transmit engine enable level |
| rx_run | output | 1 | Receive engine enable level |
| tx_start | output | 1 | Transmit engine start pulse |
| rx_start | output | 1 | Receive engine start pulse |
| rx_bd_idx | output | 9 | Receive descriptor ring pointer |
| min_len | output | 16 | Minimum frame length |
| max_len | output | 16 | Maximum frame length |
| mac_addr | output | 48 | Station address, byte k at bits 8k+7:8k |

## Verification
Some properties are watched on every cycle:
- start pulses only ever appear on a genuine rising enable;
- a soft reset always lands MODE and the ring pointer on their defaults;
- cleared pending bits stay cleared unless a new event arrives;
- irq never rises without an enabled pending bit behind it;
- an unmapped read returns zero and an unmapped write leaves MODE alone.

Other behaviours can only be shown by the bench's sweeps: the full reset table, the per-register writable masks, the descriptor window mapping over every word, the byte packing of the station address, and the set-wins outcome when an event and a clear meet on one bit.

// File: rtl/macreg_pkg.sv
package macreg_pkg;

  localparam int NUM_REGS  = 20;
  localparam int REG_IDX_W = 5;
  localparam int CNT_W     = 8;

  localparam int W_MODE    = 0;
  localparam int W_ISRC    = 1;
  localparam int W_IMASK   = 2;
  localparam int W_IPG_BB  = 3;
  localparam int W_IPG_NB1 = 4;
  localparam int W_IPG_NB2 = 5;
  localparam int W_FLEN    = 6;
  localparam int W_COLL    = 7;
  localparam int W_TXBD    = 8;
  localparam int W_FLOW    = 9;
  localparam int W_MG_MODE = 10;
  localparam int W_MG_CMD  = 11;
  localparam int W_MG_ADDR = 12;
  localparam int W_MG_WDAT = 13;
  localparam int W_MG_RDAT = 14;
  localparam int W_MG_STAT = 15;
  localparam int W_STA_LO  = 16;
  localparam int W_STA_HI  = 17;
  localparam int W_HASH_LO = 18;
  localparam int W_HASH_HI = 19;

  localparam int MODE_RX_EN    = 0;
  localparam int MODE_TX_EN    = 1;
  localparam int MODE_SOFT_RST = 11;

  function automatic logic [31:0] reset_val(input int idx);
    case (idx)
      W_MODE:    return 32'h0000_A000;
      W_IPG_BB:  return 32'h0000_0012;
      W_IPG_NB1: return 32'h0000_000C;
      W_IPG_NB2: return 32'h0000_0012;
      W_FLEN:    return 32'h003C_0600;
      W_COLL:    return 32'h000F_003F;
      W_TXBD:    return 32'h0000_0040;
      W_MG_MODE: return 32'h0000_0064;
      default:   return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] wr_mask(input int idx, input int nirq);
    case (idx)
      W_MODE:                           return 32'h0001_FFFF;
      W_ISRC, W_IMASK:                  return (32'd1 << nirq) - 32'd1;
      W_IPG_BB, W_IPG_NB1, W_IPG_NB2:   return 32'h0000_007F;
      W_COLL:                           return 32'h003F_003F;
      W_TXBD:                           return 32'h0000_00FF;
      W_FLOW, W_MG_CMD, W_MG_STAT:      return 32'h0000_0007;
      W_MG_MODE:                        return 32'h0000_01FF;
      W_MG_ADDR:                        return 32'h0000_1F1F;
      W_MG_WDAT, W_MG_RDAT, W_STA_HI:   return 32'h0000_FFFF;
      default:                          return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [CNT_W:0] rx_idx_of(input logic [CNT_W-1:0] cnt);
    return {cnt, 1'b0};
  endfunction

  function automatic logic [47:0] sta_pack(input logic [31:0] lo, input logic [15:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/macreg_decode.sv
module macreg_decode
  import macreg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BD_BASE  = 256,
  parameter int BD_WORDS = 64,
  localparam int BD_IDX_W = (BD_WORDS > 1) ? $clog2(BD_WORDS) : 1
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 reg_hit,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic [NUM_REGS-1:0]  reg_sel,
  output logic                 bd_hit,
  output logic [BD_IDX_W-1:0]  bd_idx
);

  localparam logic [ADDR_W:0] REG_END = (ADDR_W+1)'(NUM_REGS);
  localparam logic [ADDR_W:0] BD_LO   = (ADDR_W+1)'(BD_BASE);
  localparam logic [ADDR_W:0] BD_HI   = (ADDR_W+1)'(BD_BASE + BD_WORDS);

  logic [ADDR_W:0] wide;
  assign wide    = {1'b0, addr};
  assign reg_hit = wide < REG_END;
  assign reg_idx = addr[REG_IDX_W-1:0];
  assign bd_hit  = (wide >= BD_LO) && (wide < BD_HI);
  assign bd_idx  = BD_IDX_W'(wide - BD_LO);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign reg_sel[i] = reg_hit && (reg_idx == REG_IDX_W'(i));
  end

endmodule

// File: rtl/macreg_bdram.sv
module macreg_bdram #(
  parameter int WORDS = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/macreg_irq.sv
module macreg_irq #(
  parameter int NUM_IRQ = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic [NUM_IRQ-1:0] evt,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] clr_bits,
  input  logic [NUM_IRQ-1:0] mask,
  output logic [NUM_IRQ-1:0] src,
  output logic               irq
);

  logic [NUM_IRQ-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      irq <= 1'b0;
    end else begin
      src <= soft_clr ? '0 : ((src & ~clr_eff) | evt);
      irq <= |(src & mask);
    end
  end

  assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((src & $past(clr_bits) & ~$past(evt)) == '0));

  assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && |evt) |=> ((src & $past(evt)) == $past(evt)));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(src & mask)));

endmodule

// File: rtl/macreg_file.sv
module macreg_file
  import macreg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BD_BASE  = 256,
  parameter int BD_WORDS = 64,
  parameter int NUM_IRQ  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  input  logic [NUM_IRQ-1:0] irq_evt,
  output logic [31:0]        rdata,
  output logic               err,
  output logic               irq,
  output logic               tx_run,
  output logic               rx_run,
  output logic               tx_start,
  output logic               rx_start,
  output logic [CNT_W:0]     rx_bd_idx,
  output logic [15:0]        min_len,
  output logic [15:0]        max_len,
  output logic [47:0]        mac_addr
);

  localparam int BD_IDX_W = (BD_WORDS > 1) ? $clog2(BD_WORDS) : 1;
  localparam int SLOTS    = 1 << REG_IDX_W;
  localparam logic [31:0]  TXBD_RST   = reset_val(W_TXBD);
  localparam logic [31:0]  MODE_RST   = reset_val(W_MODE);
  localparam logic [CNT_W:0] RX_IDX_RST = rx_idx_of(TXBD_RST[CNT_W-1:0]);

  logic                 reg_hit, bd_hit;
  logic [REG_IDX_W-1:0] reg_idx;
  logic [NUM_REGS-1:0]  reg_sel;
  logic [BD_IDX_W-1:0]  bd_idx;
  logic [31:0]          bd_rd, reg_rd;
  logic [NUM_IRQ-1:0]   isrc;
  logic [SLOTS*32-1:0]  reg_flat;
  logic                 mode_wr, soft_rst, txbd_wr;

  macreg_decode #(.ADDR_W(ADDR_W), .BD_BASE(BD_BASE), .BD_WORDS(BD_WORDS)) u_dec (
    .addr(addr), .reg_hit(reg_hit), .reg_idx(reg_idx), .reg_sel(reg_sel),
    .bd_hit(bd_hit), .bd_idx(bd_idx)
  );

  macreg_bdram #(.WORDS(BD_WORDS), .IDX_W(BD_IDX_W)) u_ram (
    .clk(clk), .we(wr_en && bd_hit), .widx(bd_idx), .wdata(wdata),
    .ridx(bd_idx), .rdata(bd_rd)
  );

  assign mode_wr  = wr_en && reg_sel[W_MODE];
  assign soft_rst = mode_wr && wdata[MODE_SOFT_RST];
  assign txbd_wr  = wr_en && reg_sel[W_TXBD];

  macreg_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .evt(irq_evt),
    .clr_we(wr_en && reg_sel[W_ISRC]), .clr_bits(wdata[NUM_IRQ-1:0]),
    .mask(reg_flat[W_IMASK*32 +: NUM_IRQ]), .src(isrc), .irq(irq)
  );

  // One storage slot per register; the pending word lives in the irq unit.
  for (genvar i = 0; i < SLOTS; i++) begin : g_reg
    if (i == W_ISRC) begin : g_src
      assign reg_flat[i*32 +: 32] = {{(32-NUM_IRQ){1'b0}}, isrc};
    end else if (i < NUM_REGS) begin : g_store
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      q <= reset_val(i);
        else if (soft_rst)               q <= reset_val(i);
        else if (wr_en && reg_sel[i])    q <= wdata & wr_mask(i, NUM_IRQ);
      end
      assign reg_flat[i*32 +: 32] = q;
    end else begin : g_hole
      assign reg_flat[i*32 +: 32] = 32'h0;
    end
  end

  assign reg_rd   = reg_flat[{reg_idx, 5'b0} +: 32];
  assign tx_run   = reg_flat[W_MODE*32 + MODE_TX_EN];
  assign rx_run   = reg_flat[W_MODE*32 + MODE_RX_EN];
  assign min_len  = reg_flat[W_FLEN*32 + 16 +: 16];
  assign max_len  = reg_flat[W_FLEN*32 +: 16];
  assign mac_addr = sta_pack(reg_flat[W_STA_LO*32 +: 32], reg_flat[W_STA_HI*32 +: 16]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bd_idx <= RX_IDX_RST;
      tx_start  <= 1'b0;
      rx_start  <= 1'b0;
    end else begin
      if (soft_rst)     rx_bd_idx <= RX_IDX_RST;
      else if (txbd_wr) rx_bd_idx <= rx_idx_of(wdata[CNT_W-1:0]);
      tx_start <= mode_wr && !soft_rst && wdata[MODE_TX_EN] && !tx_run;
      rx_start <= mode_wr && !soft_rst && wdata[MODE_RX_EN] && !rx_run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 32'h0;
      err   <= 1'b0;
    end else begin
      err <= (rd_en || wr_en) && !(reg_hit || bd_hit);
      if (rd_en) rdata <= reg_hit ? reg_rd : (bd_hit ? bd_rd : 32'h0);
    end
  end

  assert_decode_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_sel) && !(reg_hit && bd_hit));

  assert_tx_start_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_run && !$past(tx_run)));

  assert_rx_start_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> (rx_run && !$past(rx_run)));

  assert_tx_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !wdata[MODE_TX_EN]) |=> !tx_run);

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (reg_flat[W_MODE*32 +: 32] == MODE_RST && rx_bd_idx == RX_IDX_RST
                  && !tx_start && !rx_start));

  assert_rx_ring_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txbd_wr |=> (rx_bd_idx == {reg_flat[W_TXBD*32 +: CNT_W], 1'b0}));

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(rd_en)) |-> (rdata == 32'h0));

  assert_unmapped_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_hit && !bd_hit) |=> $stable(reg_flat[W_MODE*32 +: 32]));

endmodule

// File: tb/sim_macreg_file.sv
module sim_macreg_file;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [6:0]  irq_evt = '0;
  logic [31:0] rdata;
  logic        err, irq, tx_run, rx_run, tx_start, rx_start;
  logic [8:0]  rx_bd_idx;
  logic [15:0] min_len, max_len;
  logic [47:0] mac_addr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [31:0] rv;
  logic        re;

  always #2 clk = ~clk;

  macreg_file u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .irq_evt(irq_evt), .rdata(rdata), .err(err), .irq(irq),
    .tx_run(tx_run), .rx_run(rx_run), .tx_start(tx_start), .rx_start(rx_start),
    .rx_bd_idx(rx_bd_idx), .min_len(min_len), .max_len(max_len), .mac_addr(mac_addr)
  );

  function automatic logic [31:0] exp_rst(input int w);
    logic [31:0] v = 32'h0;
    if (w == 0)  v = 32'hA000;
    if (w == 3 || w == 5) v = 32'h12;
    if (w == 4)  v = 32'h0C;
    if (w == 6)  v = 32'h003C0600;
    if (w == 7)  v = 32'h000F003F;
    if (w == 8)  v = 32'h40;
    if (w == 10) v = 32'h64;
    return v;
  endfunction

  function automatic logic [31:0] exp_mask(input int w);
    logic [31:0] m = 32'hFFFFFFFF;
    if (w == 0) m = 32'h1FFFF;
    if (w >= 1 && w <= 5) m = 32'h7F;
    if (w == 7) m = 32'h003F003F;
    if (w == 8) m = 32'hFF;
    if (w == 9 || w == 11 || w == 15) m = 32'h7;
    if (w == 10) m = 32'h1FF;
    if (w == 12) m = 32'h1F1F;
    if (w == 13 || w == 14 || w == 17) m = 32'hFFFF;
    return m;
  endfunction

  function automatic logic [31:0] bdpat(input int k);
    logic [7:0] b = 8'(k);
    return {b ^ 8'hC3, ~b, b + 8'd17, 8'h5A};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; e = err;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 20; i++) begin
      rd(10'(i), rv, re);
      chk($sformatf("R1 reset word %0d", i), rv, exp_rst(i));
      chk("R10 mapped read no err", re, 0);
    end
    chk("R1 rx_bd_idx reset", rx_bd_idx, 9'h080);
    chk("R12 reset min_len", min_len, 16'h003C);
    chk("R12 reset max_len", max_len, 16'h0600);
    chk("R8 reset run", {tx_run, rx_run}, 0);
    chk("R4 reset irq", irq, 0);

    // R11 rdata holds while rd_en is low
    rd(10'd7, rv, re);
    repeat (2) @(negedge clk);
    chk("R11 rdata hold", rdata, 32'h000F003F);

    // R2 write masks
    for (int i = 1; i < 20; i++) begin
      if (i == 1) continue;
      for (int p = 0; p < 3; p++) begin
        logic [31:0] d;
        d = (p == 0) ? 32'hFFFFFFFF : (p == 1) ? 32'h0 : (32'h5A5A5A5A ^ (32'(i) * 32'h01000193));
        wr(10'(i), d);
        rd(10'(i), rv, re);
        chk($sformatf("R2 mask word %0d pat %0d", i, p), rv, d & exp_mask(i));
      end
    end
    wr(10'd2, 32'h0);

    // R9 descriptor window
    for (int k = 0; k < 64; k++) wr(10'(256 + k), bdpat(k));
    for (int k = 0; k < 64; k++) begin
      rd(10'(256 + k), rv, re);
      chk($sformatf("R9 bd word %0d", k), rv, bdpat(k));
    end

    // R10 unmapped reads
    for (int w = 20; w < 256; w++) begin
      rd(10'(w), rv, re);
      chk("R10 unmapped read data", rv, 0);
      chk("R10 unmapped read err", re, 1);
    end
    for (int w = 320; w < 1024; w += 37) begin
      rd(10'(w), rv, re);
      chk("R10 above window data", {re, rv}, {1'b1, 32'h0});
    end
    // R10 unmapped writes are ignored
    wr(10'd4, 32'h11);
    wr(10'd36, 32'hFFFF);
    chk("R10 write err strobe", err, 1);
    @(negedge clk);
    chk("R10 err single cycle", err, 0);
    wr(10'd320, 32'hDEADBEEF);
    rd(10'd4, rv, re);
    chk("R10 alias reg untouched", rv, 32'h11);
    rd(10'd256, rv, re);
    chk("R10 alias bd untouched", rv, bdpat(0));

    // R3 pending bits
    @(negedge clk) irq_evt = 7'h7F;
    @(negedge clk) irq_evt = 7'h00;
    rd(10'd1, rv, re);
    chk("R3 events set", rv, 32'h7F);
    chk("R4 masked irq low", irq, 0);
    wr(10'd1, 32'h05);
    rd(10'd1, rv, re);
    chk("R3 w1c", rv, 32'h7A);
    @(negedge clk);
    addr = 10'd1; wdata = 32'h01; wr_en = 1'b1; irq_evt = 7'h01;
    @(negedge clk);
    wr_en = 1'b0; irq_evt = 7'h00;
    rd(10'd1, rv, re);
    chk("R3 set wins", rv, 32'h7B);

    // R4 interrupt line
    wr(10'd2, 32'h01);
    chk("R4 irq lag", irq, 0);
    @(negedge clk);
    chk("R4 irq asserted", irq, 1);
    wr(10'd1, 32'h01);
    @(negedge clk);
    chk("R4 irq after clear", irq, 0);
    wr(10'd2, 32'h04);
    @(negedge clk);
    chk("R4 unpending enable", irq, 0);
    wr(10'd2, 32'h08);
    @(negedge clk);
    chk("R4 second source", irq, 1);

    // R6 station address
    wr(10'd16, 32'h33221100);
    wr(10'd17, 32'hDEAD5544);
    chk("R6 mac_addr", mac_addr, 48'h554433221100);
    rd(10'd17, rv, re);
    chk("R6 sta_hi read", rv, 32'h5544);

    // R5 descriptor count and ring pointer
    wr(10'd8, 32'h1234);
    chk("R5 ring idx", rx_bd_idx, 9'h068);
    rd(10'd8, rv, re);
    chk("R5 count kept", rv, 32'h34);
    wr(10'd8, 32'hFF);
    chk("R5 ring idx max", rx_bd_idx, 9'h1FE);
    wr(10'd8, 32'h0);
    chk("R5 ring idx zero", rx_bd_idx, 9'h000);

    // R12 frame bounds
    wr(10'd6, 32'h00400700);
    chk("R12 min/max", {min_len, max_len}, 32'h00400700);

    // R8 engine enables
    wr(10'd0, 32'h2);
    chk("R8 tx start pulse", {tx_start, rx_start, tx_run, rx_run}, 4'b1010);
    @(negedge clk);
    chk("R8 tx pulse ends", tx_start, 0);
    wr(10'd0, 32'h3);
    chk("R8 rx start only", {tx_start, rx_start}, 2'b01);
    wr(10'd0, 32'h1);
    chk("R8 tx stop", {tx_start, tx_run, rx_run}, 3'b001);
    wr(10'd0, 32'h3);
    chk("R8 tx restart", {tx_start, rx_start}, 2'b10);
    rd(10'd0, rv, re);
    chk("R8 mode read", rv, 32'h3);

    // R7 soft reset
    wr(10'd0, 32'h803);
    chk("R7 no start, stopped", {tx_start, rx_start, tx_run, rx_run}, 0);
    chk("R7 ring idx", rx_bd_idx, 9'h080);
    chk("R7 mac cleared", mac_addr, 0);
    for (int i = 0; i < 20; i++) begin
      rd(10'(i), rv, re);
      chk($sformatf("R7 default word %0d", i), rv, exp_rst(i));
    end
    rd(10'd263, rv, re);
    chk("R7 bd kept", rv, bdpat(7));
    chk("R7 irq low", irq, 0);

    finish_run();
  end

endmodule